// File: doc/BRIEF.md
# Memory Barrier Stall Controller

This block enforces two kinds of memory barrier for a processor pipeline. It keeps a count of the explicit memory transactions that the memory side has accepted but not yet answered. When a barrier arrives, the block holds the pipeline until that count drains to zero. A full-synchronisation barrier holds back the issue of every later instruction. A memory-ordering barrier holds back only later memory requests, so instructions that do not touch memory keep flowing.

The load/store unit's requests pass through the block on a valid/ready pair. While a memory stall is active, the block drops valid towards memory and ready towards the load/store unit, so no request is lost. A barrier is a write-only trigger. Its data word and the privilege level of the requester have no effect. One barrier is tracked at a time. A second barrier sees its ready low until the first one completes. Each barrier ends with a single-cycle done pulse. If the count is already zero when a barrier arrives, the pulse comes in the same cycle.

Top module: `mem_barrier_ctrl`

## Requirements
- R1: The outstanding count resets to 0. It rises by one on each accepted memory request (mem_req_valid_o and mem_req_ready_i both high) and falls by one on each mem_rsp_i pulse. When both happen in one cycle, the count is unchanged. A response while the count is 0 leaves it at 0.
- R2: A barrier with fence_kind_i = 1 (full synchronisation) drives both issue_stall_o and memreq_stall_o high in every cycle it is active while the count is nonzero.
- R3: A barrier with fence_kind_i = 0 (memory ordering) drives memreq_stall_o high while the count is nonzero and leaves issue_stall_o low.
- R4: A barrier is active while it is pending, or in the cycle it arrives (fence_valid_i and fence_ready_o both high). If the count is 0 in that cycle, fence_done_o is high in the same cycle and neither stall is raised.
- R5: While memreq_stall_o is high, mem_req_valid_o and lsu_req_ready_o are both low. Otherwise mem_req_valid_o follows lsu_req_valid_i and lsu_req_ready_o follows mem_req_ready_i.
- R6: fence_done_o is high for exactly one cycle per barrier: the first cycle in which the barrier is active and the count is 0.
- R7: fence_ready_o is low while a barrier is pending. A barrier offered meanwhile is held and is taken in the cycle after the pending one completes.
- R8: The count saturates at 2^CNT_W-1 (15 by default). An accept at that value sets cnt_ovf_o, which stays high until reset.
- R9: The values of fence_wdata_i and fence_user_i have no effect on any output.
- R10: After reset, fence_ready_o is 1 and issue_stall_o, memreq_stall_o, fence_done_o and cnt_ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fence_valid_i | input | 1 | Barrier request |
| fence_kind_i | input | 1 | 1 = full synchronisation, 0 = memory ordering |
| fence_wdata_i | input | 32 | Data written with the barrier (ignored) |
| fence_user_i | input | 1 | Requester runs unprivileged (ignored) |
| fence_ready_o | output | 1 | Barrier can be taken this cycle |
| fence_done_o | output | 1 | One-cycle barrier completion pulse |
| issue_stall_o | output | 1 | Hold all later instruction issue |
| memreq_stall_o | output | 1 | Hold later memory requests |
| lsu_req_valid_i | input | 1 | Memory request from the load/store unit |
| lsu_req_ready_o | output | 1 | Ready back to the load/store unit |
| mem_req_valid_o | output | 1 | Memory request towards memory |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_i | input | 1 | One response pulse per completed transaction |
| cnt_ovf_o | output | 1 | Sticky counter saturation flag |

## Verification
A count that is off by one does not show until the next barrier. That barrier then releases one response early, or stays stalled one response too long. So the bench checks the exact cycle of each done pulse against its own count of accepts and responses. A stuck pending flag shows at once as fence_ready_o staying low, or as a second done pulse. A counter that wraps instead of saturating reads as zero after the sixteenth accept. A barrier issued after that would finish immediately instead of waiting for fifteen responses.

// File: rtl/mbar_pkg.sv
package mbar_pkg;

  typedef enum logic {
    FENCE_MEM = 1'b0,
    FENCE_ALL = 1'b1
  } fence_kind_e;

  // A full-sync barrier holds every later instruction, not only memory ones.
  function automatic logic holds_issue(fence_kind_e kind);
    return kind == FENCE_ALL;
  endfunction

endpackage

// File: rtl/mbar_txn_counter.sv
module mbar_txn_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, sat_hit;

  // Returns the next count; saturates at CNT_MAX and floors at zero.
  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c,
                                                   logic up, logic down);
    logic [CNT_W-1:0] r;
    r = c;
    if (up && !down && c != CNT_MAX)        r = c + CNT_ONE;
    else if (down && !up && c != '0)        r = c - CNT_ONE;
    return r;
  endfunction

  always_comb begin
    cnt_d   = next_count(cnt_q, inc_i, dec_i);
    sat_hit = inc_i && !dec_i && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_q | sat_hit;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/mbar_fence_track.sv
module mbar_fence_track
  import mbar_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fence_valid_i,
  input  fence_kind_e fence_kind_i,
  input  logic        drained_i,
  output logic        fence_ready_o,
  output logic        active_o,
  output fence_kind_e kind_o,
  output logic        done_o,
  output logic        pend_o
);

  logic        pend_q;
  fence_kind_e kind_q;
  logic        arrive;

  assign fence_ready_o = !pend_q;
  assign arrive        = fence_valid_i && !pend_q;
  assign active_o      = pend_q || arrive;
  assign kind_o        = pend_q ? kind_q : fence_kind_i;
  assign done_o        = active_o && drained_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= FENCE_MEM;
    end else begin
      pend_q <= active_o && !drained_i;
      if (arrive) kind_q <= fence_kind_i;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/mbar_req_gate.sv
module mbar_req_gate (
  input  logic hold_i,
  input  logic lsu_req_valid_i,
  output logic lsu_req_ready_o,
  output logic mem_req_valid_o,
  input  logic mem_req_ready_i,
  output logic accept_o
);

  assign mem_req_valid_o = lsu_req_valid_i && !hold_i;
  assign lsu_req_ready_o = mem_req_ready_i && !hold_i;
  assign accept_o        = mem_req_valid_o && mem_req_ready_i;

endmodule

// File: rtl/mem_barrier_ctrl.sv
module mem_barrier_ctrl
  import mbar_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fence_valid_i,
  input  logic        fence_kind_i,
  input  logic [31:0] fence_wdata_i,
  input  logic        fence_user_i,
  output logic        fence_ready_o,
  output logic        fence_done_o,
  output logic        issue_stall_o,
  output logic        memreq_stall_o,
  input  logic        lsu_req_valid_i,
  output logic        lsu_req_ready_o,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  input  logic        mem_rsp_i,
  output logic        cnt_ovf_o
);

  // Named internal events, also used by the bound checker.
  logic [CNT_W-1:0] cnt_q;
  logic             drained;
  logic             acc_evt;
  logic             rsp_evt;
  logic             fence_active;
  logic             pend_q;
  fence_kind_e      active_kind;

  // The barrier data and privilege level carry no meaning here.
  logic unused_fence_bits;
  assign unused_fence_bits = ^{fence_wdata_i, fence_user_i};

  assign rsp_evt = mem_rsp_i;

  mbar_txn_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (acc_evt),
    .dec_i  (rsp_evt),
    .cnt_o  (cnt_q),
    .zero_o (drained),
    .ovf_o  (cnt_ovf_o)
  );

  mbar_fence_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .fence_valid_i (fence_valid_i),
    .fence_kind_i  (fence_kind_e'(fence_kind_i)),
    .drained_i     (drained),
    .fence_ready_o (fence_ready_o),
    .active_o      (fence_active),
    .kind_o        (active_kind),
    .done_o        (fence_done_o),
    .pend_o        (pend_q)
  );

  assign memreq_stall_o = fence_active && !drained;
  assign issue_stall_o  = memreq_stall_o && holds_issue(active_kind);

  mbar_req_gate u_gate (
    .hold_i          (memreq_stall_o),
    .lsu_req_valid_i (lsu_req_valid_i),
    .lsu_req_ready_o (lsu_req_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .accept_o        (acc_evt)
  );

endmodule

// File: rtl/mbar_checker.sv
module mbar_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fence_valid_i,
  input logic             fence_ready_o,
  input logic             fence_done_o,
  input logic             issue_stall_o,
  input logic             memreq_stall_o,
  input logic             mem_req_valid_o,
  input logic             lsu_req_ready_o,
  input logic             cnt_ovf_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             acc_evt,
  input logic             rsp_evt,
  input logic             pend_q
);

  // R1: simultaneous accept and response keep the count
  a_r1_balanced_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && rsp_evt) |=> cnt_q == $past(cnt_q));

  // R2: a full-sync stall always implies the memory stall
  a_r2_issue_implies_mem: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall_o |-> memreq_stall_o);

  // R4: no stall with an empty count
  a_r4_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !memreq_stall_o);

  // R5: no request leaks past a memory stall
  a_r5_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
    memreq_stall_o |-> (!mem_req_valid_o && !lsu_req_ready_o && !acc_evt));

  // R6: after a done pulse the slot is free again
  a_r6_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done_o |=> !pend_q);

  // R7: a pending barrier is either still stalling or finishing
  a_r7_pending_state: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_ready_o |-> (memreq_stall_o ^ fence_done_o));

  // R8: overflow flag is sticky
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ovf_o |=> cnt_ovf_o);

  // R8: count never leaves the saturated value on an accept alone
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && acc_evt && !rsp_evt) |=> (cnt_q == {CNT_W{1'b1}} && cnt_ovf_o));

  // R7: a barrier offered while one pends does not start a new one
  a_r7_second_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid_i && pend_q && !fence_done_o) |=> pend_q);

endmodule

bind mem_barrier_ctrl mbar_checker #(.CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fence_valid_i   (fence_valid_i),
  .fence_ready_o   (fence_ready_o),
  .fence_done_o    (fence_done_o),
  .issue_stall_o   (issue_stall_o),
  .memreq_stall_o  (memreq_stall_o),
  .mem_req_valid_o (mem_req_valid_o),
  .lsu_req_ready_o (lsu_req_ready_o),
  .cnt_ovf_o       (cnt_ovf_o),
  .cnt_q           (cnt_q),
  .acc_evt         (acc_evt),
  .rsp_evt         (rsp_evt),
  .pend_q          (pend_q)
);

// File: tb/mem_barrier_ctrl_bench.sv
`timescale 1ns/1ps
module mem_barrier_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fence_valid_i = 1'b0;
  logic        fence_kind_i = 1'b0;
  logic [31:0] fence_wdata_i = '0;
  logic        fence_user_i = 1'b0;
  logic        fence_ready_o, fence_done_o, issue_stall_o, memreq_stall_o;
  logic        lsu_req_valid_i = 1'b0;
  logic        lsu_req_ready_o, mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic        mem_rsp_i = 1'b0;
  logic        cnt_ovf_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mem_barrier_ctrl u_mem_barrier_ctrl (.*);

  // Stimulus {fv,fk,rv,rr,rsp} | expected {fready,istall,mstall,done,mvalid,lready}
  localparam logic [10:0] VEC [0:15] = '{
    11'b00110_100011,  // accept, count 0->1
    11'b00110_100011,  // accept, 1->2
    11'b10110_101000,  // memory barrier arrives, requests held (R3, R5)
    11'b00111_001000,  // pending, response 2->1
    11'b11001_001000,  // second barrier held, response 1->0 (R7)
    11'b11110_000111,  // first barrier done, request flows, 0->1 (R6)
    11'b11010_111000,  // full barrier taken, count 1 (R2)
    11'b00111_011000,  // response 1->0
    11'b00000_000100,  // full barrier done
    11'b11110_100111,  // barrier at zero count finishes at once (R4)
    11'b00111_100011,  // accept and response together, count stays 1 (R1)
    11'b10100_101000,  // memory barrier with count 1
    11'b00001_001000,  // response 1->0
    11'b00100_000110,  // done, memory not ready
    11'b00001_100000,  // stray response at zero (R1)
    11'b11000_100100   // barrier finishes at once: count did not underflow
  };

  task automatic chk(string what, string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic fv, logic fk, logic rv, logic rr, logic rsp);
    @(negedge clk);
    fence_valid_i   = fv;
    fence_kind_i    = fk;
    lsu_req_valid_i = rv;
    mem_req_ready_i = rr;
    mem_rsp_i       = rsp;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fence_valid_i = 0; lsu_req_valid_i = 0; mem_req_ready_i = 0; mem_rsp_i = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    #3;
    chk("ready after reset", "R10", fence_ready_o, 1'b1);
    chk("issue stall after reset", "R10", issue_stall_o, 1'b0);
    chk("mem stall after reset", "R10", memreq_stall_o, 1'b0);
    chk("done after reset", "R10", fence_done_o, 1'b0);
    chk("ovf after reset", "R10", cnt_ovf_o, 1'b0);

    // Table walk; data word and privilege bit vary per step (R9).
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
      fence_wdata_i = 32'h9E37_79B9 * (i + 1);
      fence_user_i  = i[0];
      #3;
      chk($sformatf("v%0d fence_ready", i), "R7", fence_ready_o, VEC[i][5]);
      chk($sformatf("v%0d issue_stall", i), "R2", issue_stall_o, VEC[i][4]);
      chk($sformatf("v%0d memreq_stall", i), "R3", memreq_stall_o, VEC[i][3]);
      chk($sformatf("v%0d fence_done", i), "R6", fence_done_o, VEC[i][2]);
      chk($sformatf("v%0d mem_req_valid", i), "R5", mem_req_valid_o, VEC[i][1]);
      chk($sformatf("v%0d lsu_req_ready", i), "R5", lsu_req_ready_o, VEC[i][0]);
    end

    // R9: identical barriers with opposite data and privilege behave alike.
    do_reset();
    drive(0, 0, 1, 1, 0);
    drive(1, 1, 0, 0, 0);
    fence_wdata_i = 32'hFFFF_FFFF; fence_user_i = 1'b1;
    #3;
    chk("stall with user bit set", "R9", issue_stall_o, 1'b1);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0);
    #3;
    chk("done with user bit set", "R9", fence_done_o, 1'b1);
    drive(0, 0, 1, 1, 0);
    drive(1, 1, 0, 0, 0);
    fence_wdata_i = 32'h0; fence_user_i = 1'b0;
    #3;
    chk("stall with user bit clear", "R9", issue_stall_o, 1'b1);

    // R8: fifteen accepts fill the counter, the sixteenth saturates it.
    do_reset();
    for (int k = 0; k < 15; k++) drive(0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 0);
    #3;
    chk("no overflow at max", "R8", cnt_ovf_o, 1'b0);
    drive(0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 0);
    #3;
    chk("overflow flag set", "R8", cnt_ovf_o, 1'b1);
    drive(1, 1, 0, 0, 0);
    #3;
    chk("barrier stalls at saturated count", "R8", issue_stall_o, 1'b1);
    for (int k = 0; k < 14; k++) drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0);
    #3;
    chk("still one outstanding after 14 responses", "R8", issue_stall_o, 1'b1);
    chk("no early done", "R6", fence_done_o, 1'b0);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0);
    #3;
    chk("done after 15th response", "R6", fence_done_o, 1'b1);
    drive(0, 0, 0, 0, 0);
    #3;
    chk("done lasts one cycle", "R6", fence_done_o, 1'b0);
    chk("overflow stays set", "R8", cnt_ovf_o, 1'b1);
    do_reset();
    #3;
    chk("reset clears overflow", "R10", cnt_ovf_o, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule